// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block sits behind the receive pin synchronizer of a LIN slave node. It takes the line value and a one-cycle strobe from a baud generator. The strobe marks the sampling point of each nominal bit. The block reads the frame header from that bit stream. It ignores all traffic until it has seen a run of dominant (0) bits long enough to count as a break. After the line returns recessive, it expects a synch character of 0x55 and then the protected identifier byte.

When a valid identifier arrives, the block raises a sticky identifier flag, keeps the byte in a register and checks the two parity bits carried in the top of the byte. A synch character other than 0x55 raises an error flag. A missing stop bit raises a framing flag and sends the block back to waiting for a break. All four flags stay set until a one-cycle status-clear pulse arrives. A fresh break at any point restarts reception of the synch character.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, `id_flag`, `sync_err`, `par_err` and `frm_err` are 0 and `id_byte` is 0x00.
- R2: Bytes that arrive before any break has been detected have no effect: no flag is set and `id_byte` keeps its value.
- R3: A break is detected when `rx_bit` is 0 on 11 consecutive strobes; a run of only 10 zeros is not a break, and the header that follows it is ignored.
- R4: If the first character after a break is not 0x55, `sync_err` is set, `id_flag` stays 0, and the following byte is ignored.
- R5: Each byte is a 0 start bit, 8 data bits least significant first, and a 1 stop bit. After a break and a 0x55 synch character, the next byte sets `id_flag` and is loaded into `id_byte`, with bit i holding the i-th data bit received.
- R6: When the identifier is stored, `par_err` is set if bit 6 differs from b0^b1^b2^b4, or if bit 7 differs from ~(b1^b3^b4^b5). Otherwise `par_err` is left unchanged.
- R7: A stop bit sampled as 0 in the synch or identifier byte sets `frm_err` and returns the block to waiting for a break, so a following identifier byte is ignored.
- R8: A one-cycle pulse on `clr_status` clears `id_flag`, `sync_err`, `par_err` and `frm_err`.
- R9: A break that arrives while a header is in progress aborts it. After the delimiter, a new synch and identifier are received normally. The truncated byte may also raise `frm_err`.
- R10: A break longer than 11 bits, such as 13 bits, is treated as one break. Synch reception begins only on the first strobe at which the line is back at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sampling point |
| rx_bit | input | 1 | Synchronized receive line value |
| clr_status | input | 1 | Pulse that clears the four status flags |
| id_flag | output | 1 | Sticky: identifier received |
| id_byte | output | 8 | Last identifier received |
| sync_err | output | 1 | Sticky: synch character was not 0x55 |
| par_err | output | 1 | Sticky: identifier parity mismatch |
| frm_err | output | 1 | Sticky: stop bit missing |

## Verification
The embedded assertions check the cycle-level rules on every clock. A detected break always moves the sequencer to the break state, and produces only one detection pulse per run. The identifier flag and the synch error can rise only from their own states. The identifier register changes only when an identifier byte completes, and a clear pulse empties all flags. Only the bench scenarios can show the end-to-end results. These cover the 10-bit versus 11-bit break threshold, bytes ignored before a break and after a bad synch or framing error, recovery from a break in mid-header, and the correct bit order and parity verdict for random identifiers.

// File: rtl/lin_hdr_pkg.sv
// Package: shared constants and sequencer states for the LIN header receiver.
// Assumes: bytes are always 8 data bits wide.
package lin_hdr_pkg;
    localparam int unsigned LIN_DATA_BITS = 8;

    typedef enum logic [1:0] {
        HS_WAIT_BRK = 2'd0,  // idle, all data discarded
        HS_IN_BRK   = 2'd1,  // break seen, waiting for recessive delimiter
        HS_SYNC     = 2'd2,  // receiving synch character
        HS_ID       = 2'd3   // receiving identifier character
    } hdr_state_t;
endpackage

// File: rtl/lin_brk_det.sv
// Module: lin_brk_det
// Counts consecutive dominant bit samples and pulses once when the run
// reaches BRK_BITS. Assumes tick marks one sample per nominal bit.
module lin_brk_det #(
    parameter int unsigned BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic brk_pulse
);
    localparam int unsigned CW = $clog2(BRK_BITS + 1);

    logic [CW-1:0] run_q;

    // Count dominant samples, saturating at BRK_BITS, cleared by a recessive sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tick) begin
            if (rx)
                run_q <= '0;
            else if (run_q != CW'(BRK_BITS))
                run_q <= run_q + 1'b1;
        end
    end

    // Pulse on the sample that completes the threshold run.
    always_comb brk_pulse = tick && !rx && (run_q == CW'(BRK_BITS - 1));

    // R10
    brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);
endmodule

// File: rtl/lin_byte_rx.sv
// Module: lin_byte_rx
// Bit-level byte capture: start bit 0, DW data bits LSB first, stop bit.
// Assumes one sample per bit on tick; en low aborts any byte in progress.
module lin_byte_rx #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          en,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          stop_ok
);
    localparam int unsigned CW = $clog2(DW + 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sr_q;

    // Hunt for start bit, shift data bits, then judge the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            sr_q     <= '0;
            done     <= 1'b0;
            stop_ok  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                active_q <= 1'b0;
            end else if (tick) begin
                if (!active_q) begin
                    if (!rx) begin
                        active_q <= 1'b1;
                        cnt_q    <= '0;
                    end
                end else if (cnt_q < CW'(DW)) begin
                    sr_q  <= {rx, sr_q[DW-1:1]};
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                    stop_ok  <= rx;
                end
            end
        end
    end

    // Expose the assembled byte.
    always_comb data = sr_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/lin_id_parity.sv
// Module: lin_id_parity
// Combinational check of the two identifier parity bits (bits 6 and 7).
module lin_id_parity (
    input  logic [7:0] id,
    output logic       par_ok
);
    logic p_lo, p_hi;

    // Compute the expected parity bits and compare with the received ones.
    always_comb begin
        p_lo   = id[0] ^ id[1] ^ id[2] ^ id[4];
        p_hi   = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        par_ok = (id[6] == p_lo) && (id[7] == p_hi);
    end
endmodule

// File: rtl/lin_hdr_rx.sv
// Module: lin_hdr_rx (top)
// Slave-side header sequencer: break -> synch (must match SYNC_CHAR) ->
// identifier, with sticky status flags. Assumes rx_bit is synchronized and
// bit_tick pulses for one clock at each bit sampling point.
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int unsigned BRK_BITS  = 11,
    parameter logic [7:0]  SYNC_CHAR = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       rx_bit,
    input  logic       clr_status,
    output logic       id_flag,
    output logic [7:0] id_byte,
    output logic       sync_err,
    output logic       par_err,
    output logic       frm_err
);
    hdr_state_t                 state_q;
    logic                       brk_pulse;
    logic                       rx_en;
    logic                       rx_done;
    logic [LIN_DATA_BITS-1:0]   rx_data;
    logic                       rx_stop_ok;
    logic                       par_ok;

    lin_brk_det #(.BRK_BITS(BRK_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx(rx_bit),
        .brk_pulse(brk_pulse)
    );

    // Byte capture runs only while a synch or identifier byte is expected.
    always_comb rx_en = (state_q == HS_SYNC) || (state_q == HS_ID);

    lin_byte_rx #(.DW(LIN_DATA_BITS)) u_byte (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx(rx_bit), .en(rx_en),
        .done(rx_done), .data(rx_data), .stop_ok(rx_stop_ok)
    );

    lin_id_parity u_par (.id(rx_data), .par_ok(par_ok));

    // Header sequencer plus sticky flags; set events override a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HS_WAIT_BRK;
            id_flag  <= 1'b0;
            id_byte  <= '0;
            sync_err <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            if (clr_status) begin
                id_flag  <= 1'b0;
                sync_err <= 1'b0;
                par_err  <= 1'b0;
                frm_err  <= 1'b0;
            end
            if (brk_pulse) begin
                state_q <= HS_IN_BRK;
            end else begin
                unique case (state_q)
                    HS_WAIT_BRK: ;
                    HS_IN_BRK: if (bit_tick && rx_bit) state_q <= HS_SYNC;
                    HS_SYNC: if (rx_done) begin
                        if (!rx_stop_ok) begin
                            frm_err <= 1'b1;
                            state_q <= HS_WAIT_BRK;
                        end else if (rx_data != SYNC_CHAR) begin
                            sync_err <= 1'b1;
                            state_q  <= HS_WAIT_BRK;
                        end else begin
                            state_q <= HS_ID;
                        end
                    end
                    HS_ID: if (rx_done) begin
                        state_q <= HS_WAIT_BRK;
                        if (!rx_stop_ok) begin
                            frm_err <= 1'b1;
                        end else begin
                            id_flag <= 1'b1;
                            id_byte <= rx_data;
                            if (!par_ok) par_err <= 1'b1;
                        end
                    end
                    default: state_q <= HS_WAIT_BRK;
                endcase
            end
        end
    end

    // R10
    brk_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> (state_q == HS_IN_BRK));

    // R5
    id_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_flag) |-> ($past(state_q) == HS_ID));

    // R4
    sync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> ($past(state_q) == HS_SYNC));

    // R2
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((state_q == HS_ID) && rx_done) |=> $stable(id_byte));

    // R8
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !rx_done) |=> (!id_flag && !sync_err && !par_err && !frm_err));
endmodule

// File: tb/sim_lin_hdr_rx.sv
module sim_lin_hdr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_bit = 1'b1;
    logic       clr_status = 1'b0;
    logic       id_flag;
    logic [7:0] id_byte;
    logic       sync_err, par_err, frm_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_id = 8'h00;

    localparam int GAP = 4;

    always #5 clk = ~clk;

    lin_hdr_rx u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .clr_status(clr_status), .id_flag(id_flag), .id_byte(id_byte),
        .sync_err(sync_err), .par_err(par_err), .frm_err(frm_err)
    );

    function automatic logic good_par(input logic [7:0] b);
        logic a, c;
        a = b[0] ^ b[1] ^ b[2] ^ b[4];
        c = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
        return (b[6] == a) && (b[7] == c);
    endfunction

    function automatic logic [7:0] with_par(input logic [5:0] v);
        logic [7:0] b;
        b = {2'b00, v};
        b[6] = b[0] ^ b[1] ^ b[2] ^ b[4];
        b[7] = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        repeat (GAP - 2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        send_bit(stop);
    endtask

    task automatic send_break(input int len);
        for (int i = 0; i < len; i++) send_bit(1'b0);
        send_bit(1'b1);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] idv;
        logic       bad_sync;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {id_flag, sync_err, par_err, frm_err}, 4'b0000);
        chk("R1 id", id_byte, 8'h00);

        // R2 bytes before a break are ignored
        send_byte(8'h55, 1'b1);
        send_byte(with_par(6'h12), 1'b1);
        settle();
        chk("R2 no flag", {id_flag, sync_err, par_err, frm_err}, 4'b0000);
        chk("R2 id kept", id_byte, 8'h00);

        // R10 / R5 13-bit break, valid header
        idv = with_par(6'h2A);
        send_break(13);
        send_bit(1'b1);
        send_byte(8'h55, 1'b1);
        send_byte(idv, 1'b1);
        settle();
        chk("R10 id_flag", id_flag, 1'b1);
        chk("R5 id_byte", id_byte, idv);
        chk("R6 parity ok", par_err, 1'b0);
        exp_id = idv;

        // R8 clear
        clear_flags();
        chk("R8 cleared", {id_flag, sync_err, par_err, frm_err}, 4'b0000);

        // R3 10-bit low run is not a break
        send_break(10);
        send_byte(8'h55, 1'b1);
        send_byte(with_par(6'h05), 1'b1);
        settle();
        chk("R3 short break", id_flag, 1'b0);
        chk("R3 id kept", id_byte, exp_id);

        // R3 exactly 11 is a break
        idv = with_par(6'h05);
        send_break(11);
        send_byte(8'h55, 1'b1);
        send_byte(idv, 1'b1);
        settle();
        chk("R3 11-bit break", id_flag, 1'b1);
        chk("R3 id", id_byte, idv);
        exp_id = idv;
        clear_flags();

        // R4 bad synch
        send_break(13);
        send_byte(8'h54, 1'b1);
        send_byte(with_par(6'h33), 1'b1);
        settle();
        chk("R4 sync_err", sync_err, 1'b1);
        chk("R4 no id", id_flag, 1'b0);
        chk("R4 id kept", id_byte, exp_id);
        clear_flags();

        // R6 bad parity
        idv = with_par(6'h17) ^ 8'h80;
        send_break(13);
        send_byte(8'h55, 1'b1);
        send_byte(idv, 1'b1);
        settle();
        chk("R6 par_err", par_err, 1'b1);
        chk("R6 id stored", id_byte, idv);
        exp_id = idv;
        clear_flags();

        // R7 framing error in synch byte
        send_break(13);
        send_byte(8'h55, 1'b0);
        send_bit(1'b1);
        send_byte(with_par(6'h01), 1'b1);
        settle();
        chk("R7 frm_err", frm_err, 1'b1);
        chk("R7 id ignored", id_flag, 1'b0);
        clear_flags();

        // R9 break mid-header restarts synch reception
        idv = with_par(6'h3C);
        send_break(13);
        send_byte(8'h55, 1'b1);
        send_break(13);
        send_byte(8'h55, 1'b1);
        send_byte(idv, 1'b1);
        settle();
        chk("R9 id_flag", id_flag, 1'b1);
        chk("R9 id_byte", id_byte, idv);
        exp_id = idv;
        clear_flags();

        // Random headers
        void'($urandom(32'h1357));
        for (int k = 0; k < 40; k++) begin
            logic exp_flag;
            idv = ($urandom % 2) ? with_par(6'($urandom)) : 8'($urandom);
            bad_sync = (($urandom % 8) == 0);
            send_break(11 + int'($urandom % 4));
            repeat ($urandom % 3) send_bit(1'b1);
            send_byte(bad_sync ? 8'hD5 : 8'h55, 1'b1);
            repeat ($urandom % 3) send_bit(1'b1);
            send_byte(idv, 1'b1);
            settle();
            exp_flag = !bad_sync;
            if (exp_flag) exp_id = idv;
            chk("R5 rand flag", id_flag, exp_flag);
            chk("R4 rand sync", sync_err, bad_sync);
            chk("R5 rand id", id_byte, exp_id);
            chk("R6 rand par", par_err, exp_flag && !good_par(idv));
            clear_flags();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule